// File: doc/BRIEF.md
# Serial EEPROM Transaction Sequencer

This block turns one host request into a complete transfer to a small two-wire serial EEPROM. The host gives a 7-bit starting memory offset, a byte count and a direction. The block then issues a series of bus operations to a separate bit engine: recovery, start plus control byte, data byte write, data byte read, and stop. Each operation is one command. The engine reports when the command has finished, whether the device acknowledged it, and the byte it read.

Reads stream out of the device from incrementing addresses. Each byte leaves on a valid-qualified output. Write data is pulled from a ready/valid byte input. Writes are split into short bursts. After each burst the block polls the device with read starts until the device acknowledges, which shows that its internal programming cycle is over. It then reads and discards the device's filler byte. The first request after reset is preceded by one bus recovery operation.

Top module: `eeseq_top`

## Requirements
- R1: The control byte sent with each transfer start is the memory offset in bits 7..1, with bit 0 equal to 1 for a read and 0 for a write.
- R2: If the control byte is not acknowledged, the block issues a stop and ends the request with `done` and `error` both high. No data byte moves in either direction.
- R3: A read of N bytes issues N byte reads from consecutive addresses and presents every byte on `rdData` with a one-cycle `rdValid`, in order. `cmdAck` is 1 on the first N-1 byte reads and 0 on the last one, which is followed by a stop.
- R4: A write is split into bursts of min(remaining, BURST_MAX) bytes. Each burst opens with its own control byte whose offset has advanced by the bytes already written. Each burst closes with a stop. Write bytes are taken from the input only while no command is pending.
- R5: A data byte that is not acknowledged ends the write with a stop, `done` and `error`.
- R6: After each burst's stop, the block repeats a start with control byte 0x01 followed by a stop until a start is acknowledged. After POLL_LIMIT unacknowledged polls it ends with `error`.
- R7: After an acknowledged poll, exactly one byte is read with `cmdAck` = 0 and then a stop is issued. The byte read is discarded and does not appear on `rdValid`.
- R8: One recovery command (op code 0) is issued after reset, before the first start of the first non-empty request. No later request issues it again.
- R9: `busy` rises in the cycle after a non-empty request is accepted and stays high until the final stop has finished. `done` is a one-cycle pulse with `busy` low. `error` is only high together with `done`.
- R10: A request with length zero raises `done` in the next cycle with `error` low, and no command is issued.
- R11: `startReq` is ignored while `busy` is high.
- R12: Only one command is outstanding at a time. `cmdValid` and its op code and byte stay stable until `engDone`, and no command is issued while idle. Op codes: 0 recover, 1 start plus byte, 2 write byte, 3 read byte, 4 stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Request strobe, taken when idle |
| startOffset | input | OFF_W | First memory offset |
| startLen | input | LEN_W | Byte count |
| startRead | input | 1 | 1 = read, 0 = write |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Failure flag, valid with done |
| wrData | input | OFF_W+1 | Write byte stream data |
| wrValid | input | 1 | Write byte available |
| wrReady | output | 1 | Write byte taken this cycle |
| rdData | output | OFF_W+1 | Read byte |
| rdValid | output | 1 | Read byte strobe |
| cmdValid | output | 1 | Command to bit engine pending |
| cmdOp | output | 3 | Command op code |
| cmdData | output | OFF_W+1 | Byte to send |
| cmdAck | output | 1 | Acknowledge to send after a byte read |
| engDone | input | 1 | Command finished |
| engAckSeen | input | 1 | Device acknowledged the command |
| engRdData | input | OFF_W+1 | Byte read by the engine |

## Verification
The bench builds the block with BURST_MAX = 4 and POLL_LIMIT = 8, instead of the default of 100 polls. With these values, a poll loop that is acknowledged on the last allowed attempt can be compared directly with one that runs out, and both cases stay only a few dozen cycles long. Lengths of up to 16 bytes give writes of one to four bursts, including bursts that end early. Offsets near the top of the address space make the address counter wrap.

// File: rtl/eeseq_pkg.sv
package eeseq_pkg;

  typedef enum logic [2:0] {
    OP_RECOVER = 3'd0,
    OP_START   = 3'd1,
    OP_WRITE   = 3'd2,
    OP_READ    = 3'd3,
    OP_STOP    = 3'd4
  } engOp_t;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_POLL,
    SEL_WR
  } byteSel_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RECOVER,
    S_CTRL,
    S_FETCH,
    S_WR,
    S_BSTOP,
    S_POLL,
    S_PSTOP,
    S_DRAIN,
    S_DSTOP,
    S_RD,
    S_STOP_OK,
    S_STOP_ERR,
    S_END_OK,
    S_END_ERR
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;
    logic     ldBurst;
    logic     consume;
    logic     clrPoll;
    logic     incPoll;
    logic     setRec;
    logic     latchWr;
    logic     pushRd;
    byteSel_t sel;
  } dpStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic lenZero;
    logic remOne;
    logic remZero;
    logic burstOne;
    logic pollDone;
    logic recovered;
    logic isRead;
  } dpStatus_t;

endpackage

// File: rtl/eeseq_dpath.sv
module eeseq_dpath
  import eeseq_pkg::*;
#(
  parameter int OFF_W      = 7,
  parameter int LEN_W      = 8,
  parameter int BURST_MAX  = 4,
  parameter int POLL_LIMIT = 100
) (
  input  logic               clk,
  input  logic               rst,
  input  dpStrobe_t          st,
  input  logic [OFF_W-1:0]   startOffset,
  input  logic [LEN_W-1:0]   startLen,
  input  logic               startRead,
  input  logic [OFF_W:0]     wrData,
  input  logic [OFF_W:0]     engRdData,
  output dpStatus_t          stat,
  output logic [OFF_W:0]     cmdByte,
  output logic [OFF_W:0]     rdData,
  output logic               rdValid
);

  localparam int BYTE_W = OFF_W + 1;
  localparam int BCNT_W = $clog2(BURST_MAX + 1);
  localparam int PCNT_W = $clog2(POLL_LIMIT + 1);

  logic [OFF_W-1:0]  offReg;
  logic [LEN_W-1:0]  remReg;
  logic [BCNT_W-1:0] burstReg;
  logic [PCNT_W-1:0] pollReg;
  logic [BYTE_W-1:0] wrByte;
  logic              recovered;
  logic              isRead;

  // transfer position: offset and bytes left
  always_ff @(posedge clk) begin
    if (rst) begin
      offReg <= '0;
      remReg <= '0;
      isRead <= 1'b0;
    end else if (st.load) begin
      offReg <= startOffset;
      remReg <= startLen;
      isRead <= startRead;
    end else if (st.consume) begin
      offReg <= offReg + OFF_W'(1);
      remReg <= remReg - LEN_W'(1);
    end
  end

  // burst byte counter
  always_ff @(posedge clk) begin
    if (rst) begin
      burstReg <= '0;
    end else if (st.ldBurst) begin
      if (remReg < LEN_W'(BURST_MAX)) burstReg <= BCNT_W'(remReg);
      else                            burstReg <= BCNT_W'(BURST_MAX);
    end else if (st.consume && !isRead) begin
      burstReg <= burstReg - BCNT_W'(1);
    end
  end

  // acknowledge-poll attempt counter
  always_ff @(posedge clk) begin
    if (rst)             pollReg <= '0;
    else if (st.clrPoll) pollReg <= '0;
    else if (st.incPoll) pollReg <= pollReg + PCNT_W'(1);
  end

  // one-time recovery flag
  always_ff @(posedge clk) begin
    if (rst)            recovered <= 1'b0;
    else if (st.setRec) recovered <= 1'b1;
  end

  // write byte holding register
  always_ff @(posedge clk) begin
    if (rst)             wrByte <= '0;
    else if (st.latchWr) wrByte <= wrData;
  end

  // read byte output register
  always_ff @(posedge clk) begin
    if (rst) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= st.pushRd;
      if (st.pushRd) rdData <= engRdData;
    end
  end

  always_comb begin
    unique case (st.sel)
      SEL_CTRL: cmdByte = {offReg, isRead};
      SEL_POLL: cmdByte = BYTE_W'(1);
      SEL_WR:   cmdByte = wrByte;
      default:  cmdByte = '0;
    endcase
  end

  assign stat.lenZero   = (startLen == '0);
  assign stat.remOne    = (remReg == LEN_W'(1));
  assign stat.remZero   = (remReg == '0);
  assign stat.burstOne  = (burstReg == BCNT_W'(1));
  assign stat.pollDone  = (pollReg == PCNT_W'(POLL_LIMIT));
  assign stat.recovered = recovered;
  assign stat.isRead    = isRead;

endmodule

// File: rtl/eeseq_ctrl.sv
module eeseq_ctrl
  import eeseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      startReq,
  input  logic      wrValid,
  input  logic      engDone,
  input  logic      engAckSeen,
  input  dpStatus_t stat,
  output dpStrobe_t st,
  output logic      cmdValid,
  output engOp_t    cmdOp,
  output logic      cmdAck,
  output logic      wrReady,
  output logic      busy,
  output logic      done,
  output logic      error
);

  seqState_t state, stateNx;

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= stateNx;
  end

  always_comb begin
    stateNx  = state;
    st       = '0;
    st.sel   = SEL_NONE;
    cmdValid = 1'b0;
    cmdOp    = OP_STOP;
    cmdAck   = 1'b0;
    wrReady  = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (startReq) begin
          if (stat.lenZero) begin
            stateNx = S_END_OK;
          end else begin
            st.load = 1'b1;
            stateNx = stat.recovered ? S_CTRL : S_RECOVER;
          end
        end
      end
      S_RECOVER: begin
        cmdValid = 1'b1;
        cmdOp    = OP_RECOVER;
        if (engDone) begin
          st.setRec = 1'b1;
          stateNx   = S_CTRL;
        end
      end
      S_CTRL: begin
        cmdValid = 1'b1;
        cmdOp    = OP_START;
        st.sel   = SEL_CTRL;
        if (engDone) begin
          if (!engAckSeen) begin
            stateNx = S_STOP_ERR;
          end else if (stat.isRead) begin
            stateNx = S_RD;
          end else begin
            st.ldBurst = 1'b1;
            stateNx    = S_FETCH;
          end
        end
      end
      S_FETCH: begin
        wrReady = 1'b1;
        if (wrValid) begin
          st.latchWr = 1'b1;
          stateNx    = S_WR;
        end
      end
      S_WR: begin
        cmdValid = 1'b1;
        cmdOp    = OP_WRITE;
        st.sel   = SEL_WR;
        if (engDone) begin
          if (!engAckSeen) begin
            stateNx = S_STOP_ERR;
          end else begin
            st.consume = 1'b1;
            stateNx    = stat.burstOne ? S_BSTOP : S_FETCH;
          end
        end
      end
      S_BSTOP: begin
        cmdValid = 1'b1;
        cmdOp    = OP_STOP;
        if (engDone) begin
          st.clrPoll = 1'b1;
          stateNx    = S_POLL;
        end
      end
      S_POLL: begin
        cmdValid = 1'b1;
        cmdOp    = OP_START;
        st.sel   = SEL_POLL;
        if (engDone) begin
          if (engAckSeen) begin
            stateNx = S_DRAIN;
          end else begin
            st.incPoll = 1'b1;
            stateNx    = S_PSTOP;
          end
        end
      end
      S_PSTOP: begin
        cmdValid = 1'b1;
        cmdOp    = OP_STOP;
        if (engDone) stateNx = stat.pollDone ? S_END_ERR : S_POLL;
      end
      S_DRAIN: begin
        cmdValid = 1'b1;
        cmdOp    = OP_READ;
        if (engDone) stateNx = S_DSTOP;
      end
      S_DSTOP: begin
        cmdValid = 1'b1;
        cmdOp    = OP_STOP;
        if (engDone) stateNx = stat.remZero ? S_END_OK : S_CTRL;
      end
      S_RD: begin
        cmdValid = 1'b1;
        cmdOp    = OP_READ;
        cmdAck   = !stat.remOne;
        if (engDone) begin
          st.consume = 1'b1;
          st.pushRd  = 1'b1;
          stateNx    = stat.remOne ? S_STOP_OK : S_RD;
        end
      end
      S_STOP_OK: begin
        cmdValid = 1'b1;
        cmdOp    = OP_STOP;
        if (engDone) stateNx = S_END_OK;
      end
      S_STOP_ERR: begin
        cmdValid = 1'b1;
        cmdOp    = OP_STOP;
        if (engDone) stateNx = S_END_ERR;
      end
      S_END_OK:  stateNx = S_IDLE;
      S_END_ERR: stateNx = S_IDLE;
      default:   stateNx = S_IDLE;
    endcase
  end

  assign done  = (state == S_END_OK) || (state == S_END_ERR);
  assign error = (state == S_END_ERR);
  assign busy  = (state != S_IDLE) && !done;

endmodule

// File: rtl/eeseq_top.sv
module eeseq_top
  import eeseq_pkg::*;
#(
  parameter int OFF_W      = 7,
  parameter int LEN_W      = 8,
  parameter int BURST_MAX  = 4,
  parameter int POLL_LIMIT = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startReq,
  input  logic [OFF_W-1:0] startOffset,
  input  logic [LEN_W-1:0] startLen,
  input  logic             startRead,
  output logic             busy,
  output logic             done,
  output logic             error,
  input  logic [OFF_W:0]   wrData,
  input  logic             wrValid,
  output logic             wrReady,
  output logic [OFF_W:0]   rdData,
  output logic             rdValid,
  output logic             cmdValid,
  output logic [2:0]       cmdOp,
  output logic [OFF_W:0]   cmdData,
  output logic             cmdAck,
  input  logic             engDone,
  input  logic             engAckSeen,
  input  logic [OFF_W:0]   engRdData
);

  dpStrobe_t strobe;
  dpStatus_t status;
  engOp_t    opSel;

  eeseq_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .startReq   (startReq),
    .wrValid    (wrValid),
    .engDone    (engDone),
    .engAckSeen (engAckSeen),
    .stat       (status),
    .st         (strobe),
    .cmdValid   (cmdValid),
    .cmdOp      (opSel),
    .cmdAck     (cmdAck),
    .wrReady    (wrReady),
    .busy       (busy),
    .done       (done),
    .error      (error)
  );

  eeseq_dpath #(
    .OFF_W      (OFF_W),
    .LEN_W      (LEN_W),
    .BURST_MAX  (BURST_MAX),
    .POLL_LIMIT (POLL_LIMIT)
  ) u_dpath (
    .clk         (clk),
    .rst         (rst),
    .st          (strobe),
    .startOffset (startOffset),
    .startLen    (startLen),
    .startRead   (startRead),
    .wrData      (wrData),
    .engRdData   (engRdData),
    .stat        (status),
    .cmdByte     (cmdData),
    .rdData      (rdData),
    .rdValid     (rdValid)
  );

  assign cmdOp = opSel;

endmodule

// File: rtl/eeseq_chk.sv
module eeseq_chk #(
  parameter int OFF_W = 7
) (
  input logic           clk,
  input logic           rst,
  input logic           busy,
  input logic           done,
  input logic           error,
  input logic           wrReady,
  input logic           rdValid,
  input logic           cmdValid,
  input logic [2:0]     cmdOp,
  input logic [OFF_W:0] cmdData,
  input logic           engDone
);

  // R12: a pending command holds until the engine finishes it
  p_cmd_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && !engDone) |=> (cmdValid && $stable(cmdOp) && $stable(cmdData)));

  // R12: no bus command outside a request
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cmdValid);

  // R9: completion strobe is a single cycle with busy low
  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_busy_end_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R2: error flag only accompanies done
  p_err_with_done_r2: assert property (@(posedge clk) disable iff (rst)
    error |-> done);

  // R4: write bytes are fetched only when no command is pending
  p_fetch_alone_r4: assert property (@(posedge clk) disable iff (rst)
    wrReady |-> !cmdValid);

  // R3: read bytes are delivered inside a request
  p_rd_in_xfer_r3: assert property (@(posedge clk) disable iff (rst)
    rdValid |-> busy);

endmodule

bind eeseq_top eeseq_chk #(.OFF_W(OFF_W)) u_eeseq_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .error    (error),
  .wrReady  (wrReady),
  .rdValid  (rdValid),
  .cmdValid (cmdValid),
  .cmdOp    (cmdOp),
  .cmdData  (cmdData),
  .engDone  (engDone)
);

// File: tb/test_eeseq_top.sv
module test_eeseq_top;
  import eeseq_pkg::*;

  localparam int OFF_W  = 7;
  localparam int LEN_W  = 8;
  localparam int BURST  = 4;
  localparam int PLIM   = 8;
  localparam int MEMSZ  = 1 << OFF_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic             startReq = 1'b0;
  logic [OFF_W-1:0] startOffset = '0;
  logic [LEN_W-1:0] startLen = '0;
  logic             startRead = 1'b0;
  logic             busy, done, error;
  logic [7:0]       wrData;
  logic             wrValid, wrReady;
  logic [7:0]       rdData;
  logic             rdValid;
  logic             cmdValid;
  logic [2:0]       cmdOp;
  logic [7:0]       cmdData;
  logic             cmdAck;
  logic             engDone = 1'b0;
  logic             engAckSeen = 1'b0;
  logic [7:0]       engRdData = '0;

  eeseq_top #(.OFF_W(OFF_W), .LEN_W(LEN_W), .BURST_MAX(BURST), .POLL_LIMIT(PLIM)) i_eeseq_top (
    .clk(clk), .rst(rst), .startReq(startReq), .startOffset(startOffset),
    .startLen(startLen), .startRead(startRead), .busy(busy), .done(done),
    .error(error), .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady),
    .rdData(rdData), .rdValid(rdValid), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdData(cmdData), .cmdAck(cmdAck), .engDone(engDone),
    .engAckSeen(engAckSeen), .engRdData(engRdData)
  );

  int nChecks = 0;
  int nFails  = 0;

  // configuration written only by the stimulus process
  int cfgPoll = 0;
  bit cfgNackCtrl = 0;
  int cfgNackAt = -1;
  logic [7:0] wrBuf [16];

  // model state written only by the engine model
  logic [7:0] mem [MEMSZ];
  logic [OFF_W-1:0] mAddr;
  logic [OFF_W-1:0] nextOff;
  bit engBusy;
  int engCnt, pollBusy, burstBytes, wrRemain, dIdx;
  bit inWrite, afterBurst, expectDrain, sawNack;
  int vio, recCnt, startsEver, opCnt, wrCtrlCnt, pollStarts, drains;
  int ackReads, noAckReads, doneCnt, rdCnt, wrIdx;
  logic [2:0] lastOp;
  logic [7:0] rdBuf [16];
  bit wrStall;

  logic [7:0] shadow [MEMSZ];

  function automatic logic [7:0] memInit(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  function automatic logic [7:0] ctrlByte(int off, bit rd);
    return {7'(off), rd};
  endfunction

  assign wrValid = !wrStall;
  assign wrData  = wrBuf[wrIdx & 15];

  wire newXfer = startReq && !busy && !done;

  // bit engine and device model
  always @(posedge clk) begin
    if (rst) begin
      engBusy <= 1'b0; engDone <= 1'b0; engCnt = 0;
      for (int i = 0; i < MEMSZ; i++) mem[i] = memInit(i);
      vio = 0; recCnt = 0; startsEver = 0; opCnt = 0; doneCnt = 0;
      pollBusy = 0; afterBurst = 0; expectDrain = 0; inWrite = 0;
      lastOp = 3'd7; mAddr = '0;
    end else begin
      engDone <= 1'b0;
      if (done) doneCnt++;
      if (newXfer) begin
        nextOff = startOffset; wrRemain = int'(startLen); dIdx = 0;
        pollBusy = 0; afterBurst = 0; expectDrain = 0; inWrite = 0; sawNack = 0;
        wrCtrlCnt = 0; pollStarts = 0; drains = 0; ackReads = 0; noAckReads = 0;
      end
      if (engBusy) begin
        if (engCnt == 0) begin engBusy <= 1'b0; engDone <= 1'b1; end
        else engCnt--;
      end else if (cmdValid && !engDone) begin
        engBusy <= 1'b1;
        engCnt = int'($urandom_range(0, 2));
        opCnt++;
        lastOp = cmdOp;
        case (cmdOp)
          3'd0: begin
            recCnt++;
            if (startsEver != 0) vio++;
            engAckSeen <= 1'b1;
          end
          3'd1: begin
            startsEver++;
            if (afterBurst) begin
              pollStarts++;
              if (cmdData != 8'h01) vio++;
              if (pollBusy > 0) begin
                pollBusy--; engAckSeen <= 1'b0;
              end else begin
                afterBurst = 0; expectDrain = 1; engAckSeen <= 1'b1;
              end
            end else if (cfgNackCtrl) begin
              sawNack = 1; engAckSeen <= 1'b0;
            end else begin
              mAddr = cmdData[7:1];
              if (!cmdData[0]) begin
                if (cmdData[7:1] != nextOff) vio++;
                inWrite = 1; burstBytes = 0; wrCtrlCnt++;
              end
              engAckSeen <= 1'b1;
            end
          end
          3'd2: begin
            if (!inWrite) vio++;
            if (dIdx == cfgNackAt) begin
              sawNack = 1; engAckSeen <= 1'b0;
            end else begin
              mem[mAddr] = cmdData; mAddr = mAddr + 1'b1; nextOff = nextOff + 1'b1;
              wrRemain--; burstBytes++;
              if (burstBytes > BURST) vio++;
              engAckSeen <= 1'b1;
            end
            dIdx++;
          end
          3'd3: begin
            if (expectDrain) begin
              if (cmdAck) vio++;
              drains++; expectDrain = 0; engRdData <= 8'h00;
            end else begin
              engRdData <= mem[mAddr]; mAddr = mAddr + 1'b1;
              if (cmdAck) ackReads++; else noAckReads++;
            end
            engAckSeen <= 1'b1;
          end
          3'd4: begin
            if (inWrite) begin
              if (!sawNack && burstBytes < BURST && wrRemain != 0) vio++;
              inWrite = 0; afterBurst = 1; pollBusy = cfgPoll;
            end
            engAckSeen <= 1'b1;
          end
          default: vio++;
        endcase
      end
    end
  end

  // write stream source and read stream sink
  always @(posedge clk) begin
    if (rst) begin
      wrIdx <= 0; rdCnt <= 0; wrStall <= 1'b0;
    end else begin
      wrStall <= ($urandom_range(0, 3) == 0);
      if (newXfer) begin
        wrIdx <= 0; rdCnt <= 0;
      end else begin
        if (wrValid && wrReady) wrIdx <= wrIdx + 1;
        if (rdValid) begin
          rdBuf[rdCnt & 15] <= rdData;
          rdCnt <= rdCnt + 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    #4000000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  // run one request and check it against the requirement model
  task automatic xfer(input int off, input int len, input bit rd, input int pollN,
                      input bit nCtrl, input int nAt, input bit expErr, input string tag);
    bit gotDone, gotErr;
    int wd, nWr, bursts, dc0, op0;
    cfgPoll = pollN; cfgNackCtrl = nCtrl; cfgNackAt = nAt;
    for (int i = 0; i < 16; i++) wrBuf[i] = 8'($urandom);
    dc0 = doneCnt; op0 = opCnt;
    @(negedge clk);
    startReq = 1'b1; startOffset = 7'(off); startLen = 8'(len); startRead = rd;
    @(negedge clk);
    gotDone = done; gotErr = error; startReq = 1'b0;
    wd = 0;
    while (!gotDone && wd < 20000) begin
      @(negedge clk); gotDone = done; gotErr = error; wd++;
    end
    check(gotDone, "R9", {tag, " done seen"}, int'(gotDone), 1);
    check(gotErr == expErr, expErr ? "R2" : "R9", {tag, " error flag"}, int'(gotErr), int'(expErr));
    @(negedge clk);
    check(doneCnt == dc0 + 1, "R9", {tag, " one done pulse"}, doneCnt - dc0, 1);
    check(vio == 0, "R4", {tag, " protocol model"}, vio, 0);
    if (len == 0) begin
      check(opCnt == op0, "R10", {tag, " no command"}, opCnt - op0, 0);
      return;
    end
    if (expErr) check(lastOp == 3'd4, "R5", {tag, " stop closes failure"}, int'(lastOp), 4);
    if (rd) begin
      if (expErr) begin
        check(rdCnt == 0, "R2", {tag, " no read data"}, rdCnt, 0);
      end else begin
        check(rdCnt == len, "R3", {tag, " byte count"}, rdCnt, len);
        for (int i = 0; i < len; i++)
          check(rdBuf[i] == shadow[(off + i) % MEMSZ], "R3", {tag, " read byte"},
                int'(rdBuf[i]), int'(shadow[(off + i) % MEMSZ]));
        check(ackReads == len - 1 && noAckReads == 1, "R3", {tag, " master ack pattern"},
              ackReads, len - 1);
      end
    end else begin
      if (nCtrl) nWr = 0;
      else if (nAt >= 0) nWr = nAt;
      else if (pollN >= PLIM) nWr = (len < BURST) ? len : BURST;
      else nWr = len;
      for (int i = 0; i < nWr; i++) shadow[(off + i) % MEMSZ] = wrBuf[i];
      for (int i = 0; i < MEMSZ; i++)
        if (mem[i] != shadow[i])
          check(0, expErr ? "R5" : "R4", {tag, " memory image"}, int'(mem[i]), int'(shadow[i]));
      nChecks++;
      if (!expErr) begin
        bursts = (len + BURST - 1) / BURST;
        check(wrCtrlCnt == bursts, "R4", {tag, " bursts"}, wrCtrlCnt, bursts);
        check(pollStarts == bursts * (pollN + 1), "R6", {tag, " poll starts"},
              pollStarts, bursts * (pollN + 1));
        check(drains == bursts, "R7", {tag, " drain reads"}, drains, bursts);
        check(noAckReads == 0 && ackReads == 0, "R7", {tag, " drain not delivered"},
              rdCnt, 0);
      end
    end
  endtask

  initial begin
    int dc0, op0, r0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < MEMSZ; i++) shadow[i] = memInit(i);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !error && !cmdValid && !wrReady && !rdValid, "R9",
          "reset state quiet", int'({busy, done, cmdValid, wrReady}), 0);

    // R10: empty request, before any recovery
    xfer(5, 0, 1'b0, 0, 1'b0, -1, 1'b0, "R10 empty");
    check(recCnt == 0, "R8", "no recovery for empty request", recCnt, 0);

    // R8 + R1 + R3: first real read triggers recovery
    xfer(3, 5, 1'b1, 0, 1'b0, -1, 1'b0, "R1 first read");
    check(recCnt == 1, "R8", "recovery once before first start", recCnt, 1);

    // R4 / R6 / R7: multi-burst write, then read back
    xfer(20, 10, 1'b0, 2, 1'b0, -1, 1'b0, "R4 write 10");
    xfer(20, 10, 1'b1, 0, 1'b0, -1, 1'b0, "R3 readback");
    check(ctrlByte(20, 1'b1) == 8'h29, "R1", "control byte layout", int'(ctrlByte(20, 1'b1)), 41);

    // R6: acknowledged on the last allowed poll, then exhaustion
    xfer(40, 3, 1'b0, PLIM - 1, 1'b0, -1, 1'b0, "R6 last poll");
    xfer(60, 6, 1'b0, PLIM, 1'b0, -1, 1'b1, "R6 exhausted");
    check(pollStarts == PLIM && drains == 0, "R6", "poll attempts at limit", pollStarts, PLIM);

    // R2: control byte not acknowledged, read and write
    xfer(9, 4, 1'b1, 0, 1'b1, -1, 1'b1, "R2 read nack");
    xfer(9, 4, 1'b0, 0, 1'b1, -1, 1'b1, "R2 write nack");

    // R5: data byte not acknowledged
    xfer(70, 7, 1'b0, 1, 1'b0, 5, 1'b1, "R5 data nack");

    // R1: wrap past the top offset
    xfer(125, 6, 1'b0, 0, 1'b0, -1, 1'b0, "R1 wrap write");
    xfer(125, 6, 1'b1, 0, 1'b0, -1, 1'b0, "R1 wrap read");

    // R11: a second request while busy is ignored
    dc0 = doneCnt;
    @(negedge clk);
    startReq = 1'b1; startOffset = 7'd30; startLen = 8'd6; startRead = 1'b1;
    @(negedge clk); startReq = 1'b0;
    repeat (6) @(negedge clk);
    startReq = 1'b1; startOffset = 7'd90; startLen = 8'd3; startRead = 1'b0;
    @(negedge clk); startReq = 1'b0;
    r0 = 0;
    while (!done && r0 < 5000) begin @(negedge clk); r0++; end
    repeat (2) @(negedge clk);
    check(rdCnt == 6, "R11", "first request completes intact", rdCnt, 6);
    check(rdBuf[0] == shadow[30], "R11", "data from first request",
          int'(rdBuf[0]), int'(shadow[30]));
    op0 = opCnt;
    repeat (30) @(negedge clk);
    check(doneCnt == dc0 + 1 && opCnt == op0, "R11", "no second request", doneCnt - dc0, 1);
    check(wrCtrlCnt == 0, "R11", "no write started", wrCtrlCnt, 0);

    // random mix
    for (int k = 0; k < 12; k++) begin
      int off, len, pn;
      bit rd;
      off = int'($urandom_range(0, MEMSZ - 1));
      len = int'($urandom_range(1, 16));
      rd  = 1'($urandom_range(0, 1));
      pn  = int'($urandom_range(0, 3));
      xfer(off, len, rd, pn, 1'b0, -1, 1'b0, rd ? "R3 random read" : "R4 random write");
    end
    check(recCnt == 1, "R8", "recovery not repeated", recCnt, 1);
    check(vio == 0, "R12", "model saw no protocol fault", vio, 0);
    finishRun();
  end

endmodule